// File: doc/BRIEF.md
# Timer with Single-Shot Pulse Width Capture

This block is an 8-bit up-counter that software sets up through a small write port. It has three counting modes. In timer mode it counts a divided system clock. In event mode it counts transitions on an external pin. In capture mode it measures a single pulse on that pin. A preload register supplies the value the counter takes after it passes its top value. Each such overflow can raise an interrupt pulse and set a sticky flag.

In capture mode, setting the enable bit only arms the counter. Nothing is counted until the pin makes the chosen transition. The counter then runs on the divided clock while the pulse lasts. When the pin returns to its idle level, the hardware clears the enable bit, and the count stays readable as the pulse length. Later pin activity has no effect until software writes the enable bit again. The pin passes through a two-stage synchronizer, and all start and stop decisions use edges seen between consecutive synchronized samples.

Top module: `pulse_timer`

## Requirements
- R1: After reset the control register, counter, preload register, interrupt pulse and sticky flag all read zero.
- R2: A write to address 2'b00 replaces the whole control register. A write to address 2'b01 always updates the preload register. It also loads the counter, but only while enable (control bit 4) is 0.
- R3: With control[7:6]=2'b10 and enable set, the counter advances once every 2^P clock cycles, where P is control[2:0]. Clearing enable freezes the count.
- R4: With control[7:6]=2'b01 and enable set, the counter advances once per synchronized pin edge. The edge is rising when control bit 3 is 1 and falling when it is 0.
- R5: With control[7:6]=2'b11, an armed counter starts only on a transition into the active level. A pin that is already at the active level when the counter is armed starts nothing, and neither does a transition back to idle.
- R6: A captured pulse that holds the active level for W clock cycles adds floor(W / 2^P) to the counter.
- R7: In capture mode, the pin returning to idle clears control bit 4 and stops the counter. Further pin pulses leave the count and the enable bit unchanged.
- R8: In timer and event modes, the enable bit stays set until software writes it.
- R9: A count tick at 8'hFF loads the preload value into the counter, and counting continues from there.
- R10: On overflow with the interrupt enable input high, the interrupt output pulses for one cycle and the sticky flag sets. With that input low, neither happens.
- R11: A write to address 2'b10 clears the sticky flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 2 | 00 control, 01 counter/preload, 10 clear flag |
| wrData | input | 8 | Write data |
| pinIn | input | 1 | Asynchronous external timer pin |
| intEn | input | 1 | Interrupt enable |
| ctrlQ | output | 8 | Control register readback |
| countQ | output | 8 | Counter readback |
| preloadQ | output | 8 | Preload register readback |
| irqPulse | output | 1 | One-cycle overflow interrupt |
| irqFlag | output | 1 | Sticky overflow flag |

## Verification
Capture mode is exercised with pulses of random width, polarity, prescaler and starting count. The expected count is floor(W/2^P) added to the start value, so any off-by-one in synchronizer latency or in prescaler phase shows up. Directed cases cover the following:
- arming while the pin already sits at the active level, which separates edge-triggered from level-triggered starts;
- a second pulse after the automatic clear, which shows whether re-triggering is ignored;
- a width of 300 at the largest divider.

Timer runs from preloads near 8'hFF, with the interrupt enable input on and off, show the reload value and whether the interrupt is masked. Event counting on both edge polarities shows whether the edge select is honoured.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } mode_e;

  localparam logic [1:0] ADDR_CTRL = 2'b00;
  localparam logic [1:0] ADDR_LOAD = 2'b01;
  localparam logic [1:0] ADDR_CLR  = 2'b10;

  typedef struct packed {
    logic countTick;
    logic swLoad;
    logic preloadWr;
    logic flagClr;
  } dpStrobe_t;
endpackage

// File: rtl/ptmr_control.sv
module ptmr_control
  import ptmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PSC_BITS    = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic       pinIn,
  output logic [7:0] ctrlQ,
  output dpStrobe_t  strobe
);
  localparam int PRE_W = (1 << PSC_BITS) - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic pinS, pinPrev, rise, fall, startEdge, stopEdge;
  logic measuring, measuringNext, hwClear, ctrlWr, preRun, preTick, eventTick;
  logic [PRE_W-1:0] pre, pscMask;
  mode_e mode;
  logic enable, edgeHigh;
  logic [PSC_BITS-1:0] psc;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= pinIn;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
    end
  endgenerate

  assign pinS = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) pinPrev <= 1'b0;
    else       pinPrev <= pinS;

  assign rise      = pinS & ~pinPrev;
  assign fall      = ~pinS & pinPrev;
  assign mode      = mode_e'(ctrlQ[7:6]);
  assign enable    = ctrlQ[4];
  assign edgeHigh  = ctrlQ[3];
  assign psc       = ctrlQ[PSC_BITS-1:0];
  assign startEdge = edgeHigh ? rise : fall;
  assign stopEdge  = edgeHigh ? fall : rise;
  assign ctrlWr    = wrEn && (wrAddr == ADDR_CTRL);

  // capture state: armed -> measuring -> done (enable dropped)
  always_comb begin
    measuringNext = 1'b0;
    if (!ctrlWr && mode == MODE_PULSE && enable) begin
      if (!measuring)    measuringNext = startEdge;
      else if (stopEdge) measuringNext = 1'b0;
      else               measuringNext = 1'b1;
    end
  end

  assign hwClear = (mode == MODE_PULSE) && enable && measuring && stopEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      measuring <= 1'b0;
      ctrlQ     <= '0;
    end else begin
      measuring <= measuringNext;
      if (ctrlWr)       ctrlQ    <= wrData;
      else if (hwClear) ctrlQ[4] <= 1'b0;
    end
  end

  // prescaler restarts from zero whenever counting is idle
  assign preRun  = ((mode == MODE_TIMER) && enable) || measuring;
  assign pscMask = ~({PRE_W{1'b1}} << psc);
  assign preTick = preRun && ((pre & pscMask) == pscMask);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)       pre <= '0;
    else if (preRun) pre <= pre + 1'b1;
    else             pre <= '0;

  assign eventTick = (mode == MODE_EVENT) && enable && startEdge;

  assign strobe.countTick = preTick || eventTick;
  assign strobe.swLoad    = wrEn && (wrAddr == ADDR_LOAD) && !enable;
  assign strobe.preloadWr = wrEn && (wrAddr == ADDR_LOAD);
  assign strobe.flagClr   = wrEn && (wrAddr == ADDR_CLR);

  a_r7_hw_clear: assert property (@(posedge clk) disable iff (!rstN)
    (measuring && stopEdge && !ctrlWr) |=> !ctrlQ[4]);

  a_r8_enable_held: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[4] && mode != MODE_PULSE && !ctrlWr) |=> ctrlQ[4]);

  a_r5_wait_for_edge: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_PULSE && !measuring && !startEdge) |=> !measuring);

  a_r7_no_count_after_done: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_PULSE && !ctrlQ[4]) |-> !strobe.countTick);
endmodule

// File: rtl/ptmr_datapath.sv
module ptmr_datapath
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] wrData,
  input  logic             intEn,
  output logic [CNT_W-1:0] countQ,
  output logic [CNT_W-1:0] preloadQ,
  output logic             irqPulse,
  output logic             irqFlag
);
  logic overflow;

  assign overflow = strobe.countTick && (countQ == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ   <= '0;
      preloadQ <= '0;
      irqPulse <= 1'b0;
      irqFlag  <= 1'b0;
    end else begin
      if (strobe.preloadWr) preloadQ <= wrData;
      if (strobe.swLoad)         countQ <= wrData;
      else if (overflow)         countQ <= preloadQ;
      else if (strobe.countTick) countQ <= countQ + 1'b1;
      irqPulse <= overflow && intEn;
      if (overflow && intEn)   irqFlag <= 1'b1;
      else if (strobe.flagClr) irqFlag <= 1'b0;
    end
  end

  a_r9_reload: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !strobe.swLoad) |=> (countQ == $past(preloadQ)));

  a_r10_masked: assert property (@(posedge clk) disable iff (!rstN)
    !intEn |=> !irqPulse);

  a_r10_flag_follows: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> irqFlag);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.countTick && !strobe.swLoad) |=> $stable(countQ));
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer
  import ptmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PSC_BITS    = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic       pinIn,
  input  logic       intEn,
  output logic [7:0] ctrlQ,
  output logic [7:0] countQ,
  output logic [7:0] preloadQ,
  output logic       irqPulse,
  output logic       irqFlag
);
  dpStrobe_t strobe;

  ptmr_control #(.SYNC_STAGES(SYNC_STAGES), .PSC_BITS(PSC_BITS)) u_control (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pinIn(pinIn), .ctrlQ(ctrlQ), .strobe(strobe)
  );

  ptmr_datapath #(.CNT_W(8)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .intEn(intEn),
    .countQ(countQ), .preloadQ(preloadQ), .irqPulse(irqPulse), .irqFlag(irqFlag)
  );
endmodule

// File: tb/pulse_timer_bench.sv
module pulse_timer_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = 2'b00;
  logic [7:0] wrData = 8'h00;
  logic pinIn = 1'b0;
  logic intEn = 1'b0;
  logic [7:0] ctrlQ, countQ, preloadQ;
  logic irqPulse, irqFlag;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pulse_timer u_pulse_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pinIn(pinIn), .intEn(intEn), .ctrlQ(ctrlQ), .countQ(countQ),
    .preloadQ(preloadQ), .irqPulse(irqPulse), .irqFlag(irqFlag)
  );

  function automatic logic [7:0] expCapture(logic [7:0] start, int width, int psc);
    return 8'(int'(start) + (width >> psc));
  endfunction

  function automatic logic [7:0] ctrlWord(logic [1:0] mode, logic en, logic edgeHigh, logic [2:0] psc);
    return {mode, 1'b0, en, edgeHigh, psc};
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic pulse(logic level, int width);
    @(negedge clk);
    pinIn = level;
    repeat (width) @(negedge clk);
    pinIn = ~level;
  endtask

  initial begin
    #500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic seenIrq;
    void'($urandom(32'h5eed_1234));
    pinIn = 1'b1;
    repeat (3) tick();
    // R1 reset values
    check("R1 ctrl", ctrlQ, 0);
    check("R1 count", countQ, 0);
    check("R1 preload", preloadQ, 0);
    check("R1 irq", {irqPulse, irqFlag}, 0);
    rstN = 1'b1;
    tick();

    // R2 load while disabled
    wr(2'b01, 8'h37);
    check("R2 count load", countQ, 8'h37);
    check("R2 preload load", preloadQ, 8'h37);
    wr(2'b01, 8'h00);
    // R3 timer, prescaler 4
    wr(2'b00, ctrlWord(2'b10, 1'b1, 1'b0, 3'd2));
    check("R2 ctrl readback", ctrlQ, 8'h92);
    repeat (16) tick();
    check("R3 timer div4", countQ, 4);
    check("R8 timer enable held", ctrlQ[4], 1);
    wr(2'b01, 8'h55);
    check("R2 enabled write keeps count", countQ, 4);
    check("R2 enabled write preload", preloadQ, 8'h55);
    wr(2'b00, ctrlWord(2'b10, 1'b0, 1'b0, 3'd2));
    repeat (8) tick();
    check("R3 frozen when disabled", countQ, 4);

    // R9/R10 overflow with interrupt
    intEn = 1'b1;
    wr(2'b01, 8'hFD);
    wr(2'b00, ctrlWord(2'b10, 1'b1, 1'b0, 3'd0));
    seenIrq = 1'b0;
    for (int i = 0; i < 10 && !seenIrq; i++) begin
      tick();
      seenIrq = irqPulse;
    end
    check("R10 irq pulse seen", seenIrq, 1);
    check("R9 reload value", countQ, 8'hFD);
    check("R10 flag set", irqFlag, 1);
    tick();
    check("R10 pulse one cycle", irqPulse, 0);
    check("R9 continues", countQ, 8'hFE);
    wr(2'b00, ctrlWord(2'b10, 1'b0, 1'b0, 3'd0));
    check("R11 flag before clear", irqFlag, 1);
    wr(2'b10, 8'h00);
    check("R11 flag cleared", irqFlag, 0);

    // R10 masked
    intEn = 1'b0;
    wr(2'b01, 8'hFD);
    wr(2'b00, ctrlWord(2'b10, 1'b1, 1'b0, 3'd0));
    seenIrq = 1'b0;
    for (int i = 0; i < 8; i++) begin
      tick();
      seenIrq |= irqPulse;
    end
    check("R10 masked no pulse", seenIrq, 0);
    check("R10 masked no flag", irqFlag, 0);
    check("R9 wrap count", countQ, 8'hFF);
    wr(2'b00, 8'h00);

    // R4 event counting
    pinIn = 1'b0;
    repeat (4) tick();
    wr(2'b01, 8'h00);
    wr(2'b00, ctrlWord(2'b01, 1'b1, 1'b1, 3'd0));
    for (int i = 0; i < 5; i++) begin
      pulse(1'b1, 2);
      repeat (2) tick();
    end
    repeat (4) tick();
    check("R4 rising edges", countQ, 5);
    wr(2'b00, ctrlWord(2'b01, 1'b1, 1'b0, 3'd0));
    for (int i = 0; i < 3; i++) begin
      pulse(1'b1, 2);
      repeat (2) tick();
    end
    repeat (4) tick();
    check("R4 falling edges", countQ, 8);
    check("R8 event enable held", ctrlQ[4], 1);
    wr(2'b00, 8'h00);

    // R6/R7 directed capture, active low
    pinIn = 1'b1;
    repeat (4) tick();
    wr(2'b01, 8'h00);
    wr(2'b00, ctrlWord(2'b11, 1'b1, 1'b0, 3'd0));
    pulse(1'b0, 10);
    repeat (5) tick();
    check("R6 capture width 10", countQ, 10);
    check("R7 enable auto cleared", ctrlQ[4], 0);
    pulse(1'b0, 6);
    repeat (5) tick();
    check("R7 second pulse ignored", countQ, 10);
    check("R7 enable stays clear", ctrlQ[4], 0);

    // R5 armed while already active
    pinIn = 1'b0;
    repeat (4) tick();
    wr(2'b01, 8'h00);
    wr(2'b00, ctrlWord(2'b11, 1'b1, 1'b0, 3'd0));
    repeat (20) tick();
    check("R5 level does not start", countQ, 0);
    @(negedge clk); pinIn = 1'b1;
    repeat (6) tick();
    check("R5 return edge does not start", countQ, 0);
    check("R5 still armed", ctrlQ[4], 1);
    pulse(1'b0, 7);
    repeat (5) tick();
    check("R5 later edge starts", countQ, 7);

    // R6 largest divider
    wr(2'b01, 8'h00);
    wr(2'b00, ctrlWord(2'b11, 1'b1, 1'b0, 3'd7));
    pulse(1'b0, 300);
    repeat (5) tick();
    check("R6 width 300 div128", countQ, 2);

    // R6/R7 random captures
    for (int it = 0; it < 24; it++) begin
      logic eh;
      int w, p;
      logic [7:0] st;
      eh = 1'($urandom_range(0, 1));
      p  = $urandom_range(0, 3);
      w  = $urandom_range(1, 60);
      st = 8'($urandom_range(0, 150));
      if (it == 0) begin w = 1; p = 0; end
      wr(2'b00, 8'h00);
      pinIn = ~eh;
      repeat (4) tick();
      wr(2'b01, st);
      wr(2'b00, ctrlWord(2'b11, 1'b1, eh, 3'(p)));
      repeat (2) tick();
      pulse(eh, w);
      repeat (5) tick();
      check("R6 random capture", countQ, expCapture(st, w, p));
      check("R7 random auto clear", ctrlQ[4], 0);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule